// File: doc/BRIEF.md
# Bus Master Error Status Register

This block gathers the error and termination events of a host-bus interface into a small set of sticky status flags. It also turns those flags into maskable interrupt requests for the local processor. A bus protocol engine, which is not part of this block, sends single-cycle strobes for these events:
- a data parity error found on its own side;
- a parity error reported by the remote side;
- the end of a transaction;
- a master abort, a target abort or a target disconnect on a transaction this block started.

The parity flag is not set at the moment the error appears. A tracker state machine remembers the error and sets the flag when the transaction finishes. The abort and disconnect flags are set on the cycle after their strobe.

The processor reads the status word and clears any flag by writing a one to its bit position. Three interrupt lines follow the flags: parity errors, aborts (master and target abort share one enable) and disconnects. When either abort flag is set, the block also sends a one-cycle pulse that sets the matching received-abort bit in a companion configuration status register.

A hardware reset and a software reset clear every flag. A partial software reset freezes parity capture: it keeps the flags already set and drops new parity errors. The tracker has three states:
- `PT_IDLE`: no parity error pending.
- `PT_ERR`: an error has been seen and the tracker waits for the end of the transaction.
- `PT_FROZEN`: the partial reset is active.

Its transitions are:
- IDLE→ERR: a qualified error arrives without end of transaction.
- ERR→IDLE: end of transaction, which sets the flag.
- any→FROZEN: partial reset asserted.
- FROZEN→IDLE or FROZEN→ERR: partial reset released.
- any→IDLE: software reset.

Top module: `bmerr_status`

## Requirements
- R1: After hardware reset (rst_n low, asynchronous) the status word, all three interrupt lines and both mirror pulses are zero.
- R2: The status word places the parity error flag at bit 6, master abort at bit 7, target abort at bit 8 and target disconnect at bit 9. All other bits always read zero.
- R3: The parity flag becomes 1 only in the cycle after a cycle with xfer_end high. It does so only when a qualified parity error was strobed since the previous end of transaction, or in that same cycle. Without xfer_end it stays unchanged.
- R4: A parity error strobe is qualified only when bus_mode equals 2'b01 (PCI mode) and is_master or is_sel_tgt is high in that cycle.
- R5: Either perr_det (detected internally) or perr_rep (reported by the remote side) counts as a parity error.
- R6: In the cycle after mst_abort, tgt_abort or tgt_disc is high together with is_master, the matching flag is 1. With is_master low, these strobes have no effect.
- R7: cfg_rma_set (or cfg_rta_set) is high for exactly the one cycle after a qualified master abort (or target abort) strobe, and is low otherwise.
- R8: A write with wr_en high clears, in the next cycle, each flag whose bit position in wr_data is 1. Flags at positions written 0 keep their value.
- R9: When a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up 1.
- R10: irq_parity equals the parity flag AND ien_parity. irq_abort equals (master abort OR target abort flag) AND ien_abort. irq_term equals the disconnect flag AND ien_term. All three are combinational from the flags, with no added cycle.
- R11: In the cycle after sw_rst is high, all four flags are 0 and any pending parity error is dropped; sw_rst takes priority over every set event.
- R12: While psw_rst is high, the flags already set keep their values and no end of transaction sets the parity flag. Parity errors strobed while it is high, or still pending when it rises, are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset, clears all flags |
| psw_rst | input | 1 | Partial software reset, freezes parity capture |
| bus_mode | input | MODE_W | Bus mode select; MODE_PCI selects PCI mode |
| is_master | input | 1 | Block is acting as bus master |
| is_sel_tgt | input | 1 | Block is a selected target |
| perr_det | input | 1 | Parity error detected internally (strobe) |
| perr_rep | input | 1 | Parity error reported by remote side (strobe) |
| xfer_end | input | 1 | End of transaction (strobe) |
| mst_abort | input | 1 | Transaction ended with master abort (strobe) |
| tgt_abort | input | 1 | Transaction ended with target abort (strobe) |
| tgt_disc | input | 1 | Transaction ended with target disconnect (strobe) |
| ien_parity | input | 1 | Parity interrupt enable |
| ien_abort | input | 1 | Shared abort interrupt enable |
| ien_term | input | 1 | Disconnect interrupt enable |
| wr_en | input | 1 | Processor write strobe to the status word |
| wr_data | input | STAT_W | Write data; ones clear flags |
| stat_word | output | STAT_W | Status word read by the processor |
| irq_parity | output | 1 | Parity error interrupt request |
| irq_abort | output | 1 | Transaction abort interrupt request |
| irq_term | output | 1 | Transaction termination interrupt request |
| cfg_rma_set | output | 1 | One-cycle pulse to set received-master-abort in the companion register |
| cfg_rta_set | output | 1 | One-cycle pulse to set received-target-abort in the companion register |

## Verification
If the tracker keeps a pending parity error it should have dropped, or drops one it should keep, the fault shows only at the next xfer_end. One cycle after that, bit 6 of the status word is wrong, and so is irq_parity when it is enabled. A wrong abort or disconnect flag shows in the status word, and in the interrupt line if enabled, one cycle after its strobe. A wrong mirror register shows as a pulse that is missing or lasts longer than one cycle. The bench runs a per-cycle reference model over long scrambled input sweeps and compares every output on every cycle, so a faulty state shows up within a cycle or two of the stimulus that exposes it.

// File: rtl/bmerr_pkg.sv
package bmerr_pkg;

    // Flag positions inside the status word (decoded by software)
    localparam int POS_DPE  = 6;
    localparam int POS_MAB  = 7;
    localparam int POS_TAB  = 8;
    localparam int POS_TDIS = 9;

    // Index of each flag inside the internal flag vector
    localparam int FI_DPE  = 0;
    localparam int FI_MAB  = 1;
    localparam int FI_TAB  = 2;
    localparam int FI_TDIS = 3;
    localparam int NFLAG   = 4;

    // Parity tracker states
    typedef enum logic [1:0] {
        PT_IDLE   = 2'd0,
        PT_ERR    = 2'd1,
        PT_FROZEN = 2'd2
    } pt_state_t;

endpackage

// File: rtl/bmerr_par_track.sv
module bmerr_par_track
    import bmerr_pkg::*;
#(
    parameter int                 MODE_W   = 2,
    parameter logic [MODE_W-1:0]  MODE_PCI = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_clr,
    input  logic              freeze,
    input  logic [MODE_W-1:0] bus_mode,
    input  logic              is_master,
    input  logic              is_sel_tgt,
    input  logic              perr_det,
    input  logic              perr_rep,
    input  logic              xfer_end,
    output logic              set_dpe
);

    pt_state_t state_q;
    pt_state_t state_d;
    logic      err_qual;

    always_comb begin
        err_qual = (perr_det || perr_rep)
                && (bus_mode == MODE_PCI)
                && (is_master || is_sel_tgt)
                && !freeze && !sw_clr;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (sw_clr) begin
            state_d = PT_IDLE;
        end else if (freeze) begin
            state_d = PT_FROZEN;
        end else begin
            unique case (state_q)
                PT_IDLE, PT_FROZEN: state_d = (err_qual && !xfer_end) ? PT_ERR : PT_IDLE;
                PT_ERR:             state_d = xfer_end ? PT_IDLE : PT_ERR;
                default:            state_d = PT_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        set_dpe = 1'b0;
        unique case (state_q)
            PT_ERR:             set_dpe = xfer_end && !freeze && !sw_clr;
            PT_IDLE, PT_FROZEN: set_dpe = xfer_end && err_qual;
            default:            set_dpe = 1'b0;
        endcase
    end

endmodule

// File: rtl/bmerr_term_capture.sv
module bmerr_term_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_clr,
    input  logic is_master,
    input  logic mst_abort,
    input  logic tgt_abort,
    input  logic tgt_disc,
    output logic set_mab,
    output logic set_tab,
    output logic set_tdis,
    output logic rma_pulse,
    output logic rta_pulse
);

    always_comb begin
        set_mab  = mst_abort && is_master && !sw_clr;
        set_tab  = tgt_abort && is_master && !sw_clr;
        set_tdis = tgt_disc  && is_master && !sw_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rma_pulse <= 1'b0;
            rta_pulse <= 1'b0;
        end else begin
            rma_pulse <= set_mab;
            rta_pulse <= set_tab;
        end
    end

endmodule

// File: rtl/bmerr_flag_bank.sv
module bmerr_flag_bank #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic [NF-1:0] set_vec,
    input  logic [NF-1:0] clr_vec,
    output logic [NF-1:0] flag_q
);

    for (genvar gi = 0; gi < NF; gi++) begin : g_flag
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= 1'b0;
            end else if (clr_all) begin
                q <= 1'b0;
            end else if (set_vec[gi]) begin
                q <= 1'b1;
            end else if (clr_vec[gi]) begin
                q <= 1'b0;
            end
        end
        assign flag_q[gi] = q;
    end

endmodule

// File: rtl/bmerr_irq_map.sv
module bmerr_irq_map
    import bmerr_pkg::*;
(
    input  logic [NFLAG-1:0] flags,
    input  logic             ien_parity,
    input  logic             ien_abort,
    input  logic             ien_term,
    output logic             irq_parity,
    output logic             irq_abort,
    output logic             irq_term
);

    always_comb begin
        irq_parity = flags[FI_DPE] && ien_parity;
        irq_abort  = (flags[FI_MAB] || flags[FI_TAB]) && ien_abort;
        irq_term   = flags[FI_TDIS] && ien_term;
    end

endmodule

// File: rtl/bmerr_status.sv
module bmerr_status
    import bmerr_pkg::*;
#(
    parameter int                STAT_W   = 16,
    parameter int                MODE_W   = 2,
    parameter logic [MODE_W-1:0] MODE_PCI = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              psw_rst,
    input  logic [MODE_W-1:0] bus_mode,
    input  logic              is_master,
    input  logic              is_sel_tgt,
    input  logic              perr_det,
    input  logic              perr_rep,
    input  logic              xfer_end,
    input  logic              mst_abort,
    input  logic              tgt_abort,
    input  logic              tgt_disc,
    input  logic              ien_parity,
    input  logic              ien_abort,
    input  logic              ien_term,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] stat_word,
    output logic              irq_parity,
    output logic              irq_abort,
    output logic              irq_term,
    output logic              cfg_rma_set,
    output logic              cfg_rta_set
);

    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] clr_vec;
    logic [NFLAG-1:0] flags;
    logic             set_dpe;
    logic             set_mab;
    logic             set_tab;
    logic             set_tdis;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    bmerr_par_track #(
        .MODE_W   (MODE_W),
        .MODE_PCI (MODE_PCI)
    ) i_par_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_clr     (sw_rst),
        .freeze     (psw_rst),
        .bus_mode   (bus_mode),
        .is_master  (is_master),
        .is_sel_tgt (is_sel_tgt),
        .perr_det   (perr_det),
        .perr_rep   (perr_rep),
        .xfer_end   (xfer_end),
        .set_dpe    (set_dpe)
    );

    bmerr_term_capture i_term_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_clr    (sw_rst),
        .is_master (is_master),
        .mst_abort (mst_abort),
        .tgt_abort (tgt_abort),
        .tgt_disc  (tgt_disc),
        .set_mab   (set_mab),
        .set_tab   (set_tab),
        .set_tdis  (set_tdis),
        .rma_pulse (cfg_rma_set),
        .rta_pulse (cfg_rta_set)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[FI_DPE]  = set_dpe;
        set_vec[FI_MAB]  = set_mab;
        set_vec[FI_TAB]  = set_tab;
        set_vec[FI_TDIS] = set_tdis;

        clr_vec          = '0;
        clr_vec[FI_DPE]  = wr_en && wr_data[POS_DPE];
        clr_vec[FI_MAB]  = wr_en && wr_data[POS_MAB];
        clr_vec[FI_TAB]  = wr_en && wr_data[POS_TAB];
        clr_vec[FI_TDIS] = wr_en && wr_data[POS_TDIS];
    end

    bmerr_flag_bank #(
        .NF (NFLAG)
    ) i_flag_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (sw_rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flag_q  (flags)
    );

    always_comb begin
        stat_word           = '0;
        stat_word[POS_DPE]  = flags[FI_DPE];
        stat_word[POS_MAB]  = flags[FI_MAB];
        stat_word[POS_TAB]  = flags[FI_TAB];
        stat_word[POS_TDIS] = flags[FI_TDIS];
    end

    bmerr_irq_map i_irq_map (
        .flags      (flags),
        .ien_parity (ien_parity),
        .ien_abort  (ien_abort),
        .ien_term   (ien_term),
        .irq_parity (irq_parity),
        .irq_abort  (irq_abort),
        .irq_term   (irq_term)
    );

endmodule

// File: rtl/bmerr_status_chk.sv
module bmerr_status_chk #(
    parameter int STAT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst,
    input logic              psw_rst,
    input logic              is_master,
    input logic              xfer_end,
    input logic              mst_abort,
    input logic              tgt_disc,
    input logic              ien_abort,
    input logic              wr_en,
    input logic [STAT_W-1:0] wr_data,
    input logic [STAT_W-1:0] stat_word,
    input logic              irq_abort,
    input logic              cfg_rma_set,
    input logic              cfg_rta_set
);

    localparam logic [STAT_W-1:0] FLAG_MASK = STAT_W'(16'h03C0);

    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word & ~FLAG_MASK) == '0);

    assert_dpe_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_word[6]) |-> $past(xfer_end));

    assert_mab_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_abort && is_master && !sw_rst) |=> stat_word[7]);

    assert_rma_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rma_set |-> stat_word[7]);

    assert_rta_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rta_set |-> stat_word[8]);

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[9] && !(tgt_disc && is_master)) |=> !stat_word[9]);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_disc && is_master && !sw_rst && wr_en && wr_data[9]) |=> stat_word[9]);

    assert_irq_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_abort == ((stat_word[7] || stat_word[8]) && ien_abort));

    assert_swrst_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (stat_word == '0));

    assert_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
        psw_rst |=> !$rose(stat_word[6]));

endmodule

bind bmerr_status bmerr_status_chk #(.STAT_W(STAT_W)) i_bmerr_status_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_rst      (sw_rst),
    .psw_rst     (psw_rst),
    .is_master   (is_master),
    .xfer_end    (xfer_end),
    .mst_abort   (mst_abort),
    .tgt_disc    (tgt_disc),
    .ien_abort   (ien_abort),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .stat_word   (stat_word),
    .irq_abort   (irq_abort),
    .cfg_rma_set (cfg_rma_set),
    .cfg_rta_set (cfg_rta_set)
);

// File: tb/test_bmerr_status.sv
module test_bmerr_status;

    localparam int CLK_PERIOD = 10;
    localparam int STAT_W     = 16;
    localparam int MODE_W     = 2;
    localparam int SWEEP_N    = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sw_rst = 1'b0, psw_rst = 1'b0;
    logic [MODE_W-1:0] bus_mode = 2'b01;
    logic              is_master = 1'b0, is_sel_tgt = 1'b0;
    logic              perr_det = 1'b0, perr_rep = 1'b0, xfer_end = 1'b0;
    logic              mst_abort = 1'b0, tgt_abort = 1'b0, tgt_disc = 1'b0;
    logic              ien_parity = 1'b0, ien_abort = 1'b0, ien_term = 1'b0;
    logic              wr_en = 1'b0;
    logic [STAT_W-1:0] wr_data = '0;
    logic [STAT_W-1:0] stat_word;
    logic              irq_parity, irq_abort, irq_term, cfg_rma_set, cfg_rta_set;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bmerr_status #(.STAT_W(STAT_W), .MODE_W(MODE_W), .MODE_PCI(2'b01)) i_bmerr_status (
        .clk, .rst_n, .sw_rst, .psw_rst, .bus_mode, .is_master, .is_sel_tgt,
        .perr_det, .perr_rep, .xfer_end, .mst_abort, .tgt_abort, .tgt_disc,
        .ien_parity, .ien_abort, .ien_term, .wr_en, .wr_data,
        .stat_word, .irq_parity, .irq_abort, .irq_term, .cfg_rma_set, .cfg_rta_set
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        sw_rst = 0; psw_rst = 0; perr_det = 0; perr_rep = 0; xfer_end = 0;
        mst_abort = 0; tgt_abort = 0; tgt_disc = 0; wr_en = 0; wr_data = '0;
    endtask

    task automatic hw_reset();
        quiet();
        rst_n = 0;
        step();
        rst_n = 1;
        step();
    endtask

    // Reference model state
    logic       m_pend;
    logic [3:0] m_flags;   // {tdis, tab, mab, dpe}
    logic       m_rma, m_rta;

    function automatic logic [STAT_W-1:0] exp_word(input logic [3:0] f);
        logic [STAT_W-1:0] w;
        w = '0;
        w[6] = f[0]; w[7] = f[1]; w[8] = f[2]; w[9] = f[3];
        return w;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset values
        chk("R1 stat in reset", 32'(stat_word), 0);
        hw_reset();
        chk("R1 stat after reset", 32'(stat_word), 0);
        chk("R1 irqs", {29'd0, irq_parity, irq_abort, irq_term}, 0);
        chk("R1 mirrors", {30'd0, cfg_rma_set, cfg_rta_set}, 0);

        // R3: error mid transaction, flag only after end
        ien_parity = 1; is_master = 1; bus_mode = 2'b01;
        perr_det = 1; step(); perr_det = 0;
        chk("R3 no set before end", 32'(stat_word[6]), 0);
        step();
        chk("R3 still pending", 32'(stat_word[6]), 0);
        xfer_end = 1; step(); xfer_end = 0;
        chk("R3 set after end", 32'(stat_word[6]), 1);
        chk("R2 exact word", 32'(stat_word), 32'h0040);
        chk("R10 irq_parity", 32'(irq_parity), 1);
        ien_parity = 0; #1;
        chk("R10 irq_parity masked", 32'(irq_parity), 0);
        // R3: end without error does not re-set after clear
        wr_en = 1; wr_data = 16'h0040; step(); quiet();
        chk("R8 clear dpe", 32'(stat_word), 0);
        xfer_end = 1; step(); quiet();
        chk("R3 end without error", 32'(stat_word), 0);

        // R4: wrong mode / not participating
        bus_mode = 2'b10; perr_det = 1; xfer_end = 1; step(); quiet();
        chk("R4 non-PCI mode", 32'(stat_word), 0);
        bus_mode = 2'b01; is_master = 0; is_sel_tgt = 0;
        perr_det = 1; xfer_end = 1; step(); quiet();
        chk("R4 not master nor target", 32'(stat_word), 0);

        // R5: remote report as selected target
        is_sel_tgt = 1; perr_rep = 1; xfer_end = 1; step(); quiet();
        chk("R5 remote report", 32'(stat_word), 32'h0040);
        wr_en = 1; wr_data = 16'h0000; step(); quiet();
        chk("R8 write zero keeps", 32'(stat_word), 32'h0040);
        is_sel_tgt = 0;

        // R6 / R7: aborts
        is_master = 0; mst_abort = 1; tgt_abort = 1; tgt_disc = 1; step(); quiet();
        chk("R6 ignored when not master", 32'(stat_word), 32'h0040);
        chk("R7 no mirror when not master", {30'd0, cfg_rma_set, cfg_rta_set}, 0);
        is_master = 1; mst_abort = 1; step(); quiet();
        chk("R6 master abort", 32'(stat_word), 32'h00C0);
        chk("R7 rma pulse", {30'd0, cfg_rma_set, cfg_rta_set}, 2'b10);
        step();
        chk("R7 rma one cycle", {30'd0, cfg_rma_set, cfg_rta_set}, 0);
        tgt_abort = 1; tgt_disc = 1; step(); quiet();
        chk("R6 tab and tdis", 32'(stat_word), 32'h03C0);
        chk("R7 rta pulse", {30'd0, cfg_rma_set, cfg_rta_set}, 2'b01);
        ien_abort = 1; ien_term = 1; #1;
        chk("R10 abort and term irqs", {30'd0, irq_abort, irq_term}, 2'b11);

        // R9: set wins over clear
        tgt_disc = 1; wr_en = 1; wr_data = 16'h0200; step(); quiet();
        chk("R9 set wins", 32'(stat_word), 32'h03C0);

        // R11: software reset
        sw_rst = 1; mst_abort = 1; step(); quiet();
        chk("R11 sw reset clears", 32'(stat_word), 0);
        perr_det = 1; step(); quiet();
        sw_rst = 1; step(); quiet();
        xfer_end = 1; step(); quiet();
        chk("R11 pending dropped", 32'(stat_word), 0);

        // R12: partial reset
        perr_det = 1; xfer_end = 1; step(); quiet();
        chk("R12 precondition", 32'(stat_word), 32'h0040);
        psw_rst = 1; step();
        chk("R12 flag kept", 32'(stat_word), 32'h0040);
        wr_en = 1; wr_data = 16'h0040; step(); wr_en = 0; wr_data = '0;
        perr_det = 1; xfer_end = 1; step(); perr_det = 0; xfer_end = 0;
        chk("R12 no capture while frozen", 32'(stat_word), 0);
        quiet();
        perr_det = 1; step(); quiet();
        psw_rst = 1; step(); quiet();
        xfer_end = 1; step(); quiet();
        chk("R12 pending dropped on freeze", 32'(stat_word), 0);

        // Sweep against reference model
        hw_reset();
        m_pend = 0; m_flags = 0; m_rma = 0; m_rta = 0;
        begin
            logic [31:0] lf;
            lf = 32'hACE1_2357;
            for (int i = 0; i < SWEEP_N; i++) begin
                logic       qual, s_dpe, s_mab, s_tab, s_tdis;
                logic [3:0] setv, clrv;
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                lf = lf ^ (lf << 13) ^ (32'(i) * 32'h9E37);
                perr_det   = lf[0] & lf[1];
                perr_rep   = lf[2] & lf[3];
                xfer_end   = lf[4] & lf[5];
                bus_mode   = (lf[6] | lf[7]) ? 2'b01 : {lf[8], 1'b0};
                is_master  = lf[9];
                is_sel_tgt = lf[10];
                mst_abort  = lf[11] & lf[12];
                tgt_abort  = lf[13] & lf[12];
                tgt_disc   = lf[14] & lf[15];
                ien_parity = lf[16]; ien_abort = lf[17]; ien_term = lf[18];
                wr_en      = lf[19] & lf[20];
                wr_data    = {lf[31:21], lf[4:0]} ^ lf[15:0];
                psw_rst    = lf[22] & lf[23] & lf[24];
                sw_rst     = lf[25] & lf[26] & lf[27] & lf[28] & lf[29];

                qual = (perr_det | perr_rep) && bus_mode == 2'b01
                    && (is_master | is_sel_tgt) && !psw_rst && !sw_rst;
                s_dpe  = xfer_end && (m_pend || qual) && !psw_rst && !sw_rst;
                s_mab  = mst_abort && is_master && !sw_rst;
                s_tab  = tgt_abort && is_master && !sw_rst;
                s_tdis = tgt_disc && is_master && !sw_rst;
                setv = {s_tdis, s_tab, s_mab, s_dpe};
                clrv = wr_en ? {wr_data[9], wr_data[8], wr_data[7], wr_data[6]} : 4'b0;
                if (sw_rst) begin
                    m_flags = 0;
                    m_pend  = 0;
                end else begin
                    m_flags = (m_flags & ~clrv) | setv;
                    if (psw_rst || xfer_end) m_pend = 0;
                    else                     m_pend = m_pend | qual;
                end
                m_rma = s_mab;
                m_rta = s_tab;

                step();
                chk("R3 sweep parity flag", 32'(stat_word[6]), 32'(m_flags[0]));
                chk("R6 sweep abort/disc flags", 32'(stat_word[9:7]), 32'(m_flags[3:1]));
                chk("R2 sweep full word", 32'(stat_word), 32'(exp_word(m_flags)));
                chk("R10 sweep irqs", {29'd0, irq_parity, irq_abort, irq_term},
                    {29'd0, m_flags[0] & ien_parity, (m_flags[1] | m_flags[2]) & ien_abort,
                     m_flags[3] & ien_term});
                chk("R7 sweep mirrors", {30'd0, cfg_rma_set, cfg_rta_set}, {30'd0, m_rma, m_rta});
            end
        end
        quiet();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule